// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the processor-facing register set of a four-channel DMA controller. A byte-wide I/O bus writes and reads it. The low address bits, after a right shift by `WSHIFT`, form a 4-bit port index. `WSHIFT` is 0 for a byte controller and 1 for a word controller. Indices 0 to 7 reach the per-channel address and count registers. Indices 8 to 15 reach the controller-wide registers: command, software request, masks, mode and the control strobes.

Each channel has a 16-bit base address, a 16-bit base count, a current address, a current progress count and a mode byte. A 16-bit value passes through the 8-bit port in two accesses. One byte-pointer flip-flop, shared by all channels, selects the low byte or the high byte. Writing a high byte reloads the channel's current registers from its base registers.

The transfer engine sits outside this block. It advances a channel's progress through `adv_chan` and reports terminal count through `tc_in`. An arbiter reads the channel registers, the mask bits and the request bits from the exported ports.

Top module: `dma_regfile`

## Requirements
- R1: After reset, all four mask bits are 1, the request and terminal-count status bits are 0, the controller-off bit is 0 and the byte pointer is 0 (low byte).
- R2: Port index = (address >> WSHIFT) & 0xF. Index 0..7 selects channel index>>1, and index bit 0 selects address (0) or count (1). A channel write loads the low byte when the pointer is 0 and the high byte when it is 1. Every channel access, read or write, toggles the pointer.
- R3: Writing a high byte to either base register of a channel sets that channel's current address to (base address << WSHIFT) and its progress to 0. A low-byte write leaves the current registers unchanged.
- R4: An address read yields the current address plus the progress, or minus the progress when mode bit 5 is 1. The returned byte is (value >> (WSHIFT + 8·pointer)) & 0xFF.
- R5: A count read yields ((base count << WSHIFT) − progress), with its byte chosen as in R4.
- R6: Index 8 loads the command. Only bit 2 (controller off, exported) is supported. A value with any other bit set is rejected and the command is left unchanged.
- R7: Index 9 uses data[1:0] as the channel. If data[2] is 1, it sets that channel's request (status bit 4+ch). Otherwise it clears that request and the channel's terminal-count bit (status bit ch).
- R8: Index 10 sets (data[2]=1) or clears (data[2]=0) the mask bit of the channel in data[1:0].
- R9: Index 11 writes data into the mode byte of the channel in data[1:0]. Fields: [1:0] channel, [3:2] operation, [4] auto-init, [5] decrement, [7:6] transfer mode.
- R10: A write to index 12 clears the byte pointer.
- R11: A write to index 13 clears the command, the status and the byte pointer, and sets all four mask bits.
- R12: A write to index 14 clears all mask bits. A write to index 15 loads them from data[3:0].
- R13: A read of index 8 returns the status (requests in [7:4], terminal counts in [3:0]). A read of index 15 returns the mask in [3:0] with [7:4] zero. Reads of indices 9 to 14 return 0x00. Read data appears on `rdata` one clock after `rd_en`.
- R14: Each cycle with `adv_chan[ch]` high adds (1 << WSHIFT) to channel ch's progress. Each cycle with `tc_in[ch]` high sets status bit ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| adv_chan | input | 4 | Per-channel progress advance from the engine |
| tc_in | input | 4 | Per-channel terminal-count pulses |
| cur_addr_o | output | 4·(16+WSHIFT) | Current addresses, channel 0 in the low slice |
| cur_cnt_o | output | 4·(16+WSHIFT) | Current progress counts |
| mode_o | output | 32 | Mode bytes, channel 0 in the low byte |
| mask_o | output | 4 | Mask bits |
| req_o | output | 4 | Request bits |
| ctrl_off_o | output | 1 | Controller-off command bit |

## Verification
The bench builds two instances side by side, one with WSHIFT=0 and one with WSHIFT=1. Both receive the same port sequence, with the bus address shifted to match each instance. The byte reads must agree across the two instances. The exported current registers of the word instance must be exactly twice those of the byte instance. This exercises the width-dependent shifts on reload, on progress advance and on readback byte selection, which a single width would leave untested.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

    localparam int NCH = 4;   // channels reached by a 4-bit index
    localparam int BW  = 16;  // base register width

    typedef enum logic [3:0] {
        PORT_CMD   = 4'h8,
        PORT_REQ   = 4'h9,
        PORT_MSK1  = 4'hA,
        PORT_MODE  = 4'hB,
        PORT_FFCLR = 4'hC,
        PORT_MRST  = 4'hD,
        PORT_MCLR  = 4'hE,
        PORT_MALL  = 4'hF
    } ctl_port_e;

    typedef struct packed {
        logic [1:0] xfer_mode;
        logic       down;
        logic       auto_init;
        logic [1:0] op;
        logic [1:0] sel;
    } mode_t;

    typedef struct packed {
        logic       chan_acc;
        logic [1:0] chan;
        logic       is_cnt;
        logic [3:0] idx;
    } port_dec_t;

    localparam logic [7:0] CMD_SUPPORTED = 8'h04;

    function automatic logic cmd_accept(input logic [7:0] d);
        return (d & ~CMD_SUPPORTED) == 8'h00;
    endfunction

    function automatic logic [7:0] pick_byte(input logic [BW-1:0] v, input logic hi);
        return hi ? v[15:8] : v[7:0];
    endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
    import dma_rf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WSHIFT = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output port_dec_t         dec
);
    logic [3:0] idx;
    logic       unused_addr;

    assign idx         = addr[WSHIFT +: 4];
    assign unused_addr = ^addr;

    always_comb begin
        dec.idx      = idx;
        dec.chan_acc = ~idx[3];
        dec.chan     = idx[2:1];
        dec.is_cnt   = idx[0];
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_rf_pkg::*;
#(
    parameter int WSHIFT = 0,
    parameter int CUR_W  = BW + WSHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_addr,
    input  logic             wr_cnt,
    input  logic             hi,
    input  logic [7:0]       wdata,
    input  logic             mode_we,
    input  mode_t            mode_in,
    input  logic             adv,
    output logic [CUR_W-1:0] cur_addr,
    output logic [CUR_W-1:0] cur_cnt,
    output mode_t            mode_o,
    output logic [CUR_W-1:0] addr_view,
    output logic [CUR_W-1:0] cnt_view
);
    localparam logic [CUR_W-1:0] STEP = CUR_W'(1) << WSHIFT;

    logic [BW-1:0] base_a, base_c, base_a_nx, base_c_nx;
    logic          reload;
    mode_t         mode_q;

    always_comb begin
        base_a_nx = base_a;
        base_c_nx = base_c;
        if (wr_addr) begin
            if (hi) base_a_nx[15:8] = wdata;
            else    base_a_nx[7:0]  = wdata;
        end
        if (wr_cnt) begin
            if (hi) base_c_nx[15:8] = wdata;
            else    base_c_nx[7:0]  = wdata;
        end
    end

    assign reload = (wr_addr | wr_cnt) & hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_a   <= '0;
            base_c   <= '0;
            cur_addr <= '0;
            cur_cnt  <= '0;
            mode_q   <= '0;
        end else begin
            base_a <= base_a_nx;
            base_c <= base_c_nx;
            if (reload) begin
                cur_addr <= CUR_W'(base_a_nx) << WSHIFT;
                cur_cnt  <= '0;
            end else if (adv) begin
                cur_cnt <= cur_cnt + STEP;
            end
            if (mode_we) mode_q <= mode_in;
        end
    end

    assign mode_o    = mode_q;
    assign addr_view = mode_q.down ? (cur_addr - cur_cnt) : (cur_addr + cur_cnt);
    assign cnt_view  = (CUR_W'(base_c) << WSHIFT) - cur_cnt;

    AST_RELOAD_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cur_cnt == '0) && (cur_addr == (CUR_W'(base_a) << WSHIFT))); // R3
    AST_LOW_KEEPS_CUR: assert property (@(posedge clk) disable iff (rst)
        ((wr_addr | wr_cnt) && !hi && !adv) |=> ($stable(cur_addr) && $stable(cur_cnt))); // R3
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && !(wr_addr | wr_cnt)) |=> (cur_cnt == $past(cur_cnt) + STEP)); // R14
endmodule

// File: rtl/dma_readback.sv
module dma_readback
    import dma_rf_pkg::*;
#(
    parameter int WSHIFT = 0,
    parameter int CUR_W  = BW + WSHIFT
) (
    input  port_dec_t                  dec,
    input  logic                       ff,
    input  logic [NCH-1:0][CUR_W-1:0]  addr_views,
    input  logic [NCH-1:0][CUR_W-1:0]  cnt_views,
    input  logic [7:0]                 status,
    input  logic [NCH-1:0]             mask,
    output logic [7:0]                 rb
);
    logic [CUR_W-1:0] sel;

    always_comb begin
        sel = dec.is_cnt ? cnt_views[dec.chan] : addr_views[dec.chan];
        rb  = 8'h00;
        if (dec.chan_acc) begin
            rb = pick_byte(sel[WSHIFT +: BW], ff);
        end else begin
            case (dec.idx)
                PORT_CMD: rb = status;
                PORT_MALL: rb = {4'h0, mask};
                default:  rb = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_rf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WSHIFT = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    input  logic [3:0]               adv_chan,
    input  logic [3:0]               tc_in,
    output logic [4*(BW+WSHIFT)-1:0] cur_addr_o,
    output logic [4*(BW+WSHIFT)-1:0] cur_cnt_o,
    output logic [31:0]              mode_o,
    output logic [3:0]               mask_o,
    output logic [3:0]               req_o,
    output logic                     ctrl_off_o
);
    localparam int CUR_W = BW + WSHIFT;

    port_dec_t dec;
    logic      ff_q, ff_nx;
    logic      cmd_off_q, cmd_off_nx;
    logic [7:0] status_q, status_nx;
    logic [NCH-1:0] mask_q, mask_nx;
    logic [7:0] rdata_q, rb_byte;

    logic ctl_wr, chan_any;
    logic w_cmd, w_req, w_msk1, w_mode, w_ffclr, w_mrst, w_mclr, w_mall;

    logic [NCH-1:0][CUR_W-1:0] addr_views, cnt_views;
    mode_t mode_arr [NCH];
    mode_t mode_in;

    dma_port_decode #(.ADDR_W(ADDR_W), .WSHIFT(WSHIFT)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    assign ctl_wr   = wr_en & ~dec.chan_acc;
    assign chan_any = (wr_en | rd_en) & dec.chan_acc;
    assign w_cmd    = ctl_wr && (dec.idx == PORT_CMD);
    assign w_req    = ctl_wr && (dec.idx == PORT_REQ);
    assign w_msk1   = ctl_wr && (dec.idx == PORT_MSK1);
    assign w_mode   = ctl_wr && (dec.idx == PORT_MODE);
    assign w_ffclr  = ctl_wr && (dec.idx == PORT_FFCLR);
    assign w_mrst   = ctl_wr && (dec.idx == PORT_MRST);
    assign w_mclr   = ctl_wr && (dec.idx == PORT_MCLR);
    assign w_mall   = ctl_wr && (dec.idx == PORT_MALL);
    assign mode_in  = mode_t'(wdata);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic wa, wc, mwe;
        assign wa  = wr_en & dec.chan_acc & (dec.chan == 2'(ch)) & ~dec.is_cnt;
        assign wc  = wr_en & dec.chan_acc & (dec.chan == 2'(ch)) &  dec.is_cnt;
        assign mwe = w_mode & (wdata[1:0] == 2'(ch));

        dma_chan_regs #(.WSHIFT(WSHIFT), .CUR_W(CUR_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_addr   (wa),
            .wr_cnt    (wc),
            .hi        (ff_q),
            .wdata     (wdata),
            .mode_we   (mwe),
            .mode_in   (mode_in),
            .adv       (adv_chan[ch]),
            .cur_addr  (cur_addr_o[ch*CUR_W +: CUR_W]),
            .cur_cnt   (cur_cnt_o[ch*CUR_W +: CUR_W]),
            .mode_o    (mode_arr[ch]),
            .addr_view (addr_views[ch]),
            .cnt_view  (cnt_views[ch])
        );
        assign mode_o[ch*8 +: 8] = mode_arr[ch];
    end

    dma_readback #(.WSHIFT(WSHIFT), .CUR_W(CUR_W)) u_rb (
        .dec        (dec),
        .ff         (ff_q),
        .addr_views (addr_views),
        .cnt_views  (cnt_views),
        .status     (status_q),
        .mask       (mask_q),
        .rb         (rb_byte)
    );

    always_comb begin
        status_nx = status_q | {4'h0, tc_in};
        if (w_req) begin
            if (wdata[2]) begin
                status_nx[{1'b1, wdata[1:0]}] = 1'b1;
            end else begin
                status_nx[{1'b1, wdata[1:0]}] = 1'b0;
                status_nx[{1'b0, wdata[1:0]}] = 1'b0;
            end
        end
        mask_nx = mask_q;
        if (w_msk1) mask_nx[wdata[1:0]] = wdata[2];
        if (w_mclr) mask_nx = '0;
        if (w_mall) mask_nx = wdata[3:0];
        cmd_off_nx = cmd_off_q;
        if (w_cmd && cmd_accept(wdata)) cmd_off_nx = wdata[2];
        ff_nx = chan_any ? ~ff_q : ff_q;
        if (w_ffclr) ff_nx = 1'b0;
        if (w_mrst) begin
            cmd_off_nx = 1'b0;
            status_nx  = '0;
            ff_nx      = 1'b0;
            mask_nx    = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ff_q      <= 1'b0;
            cmd_off_q <= 1'b0;
            status_q  <= '0;
            mask_q    <= '1;
            rdata_q   <= '0;
        end else begin
            ff_q      <= ff_nx;
            cmd_off_q <= cmd_off_nx;
            status_q  <= status_nx;
            mask_q    <= mask_nx;
            if (rd_en) rdata_q <= rb_byte;
        end
    end

    assign rdata      = rdata_q;
    assign mask_o     = mask_q;
    assign req_o      = status_q[7:4];
    assign ctrl_off_o = cmd_off_q;

    AST_MRST_STATE: assert property (@(posedge clk) disable iff (rst)
        w_mrst |=> (mask_q == 4'hF) && (status_q == 8'h00) && !cmd_off_q && !ff_q); // R11
    AST_FF_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        chan_any |=> (ff_q != $past(ff_q))); // R2
    AST_FF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        w_ffclr |=> !ff_q); // R10
    AST_CMD_REJECT: assert property (@(posedge clk) disable iff (rst)
        (w_cmd && !cmd_accept(wdata)) |=> $stable(cmd_off_q)); // R6
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        w_mclr |=> (mask_q == 4'h0)); // R12
    AST_REQ_SET: assert property (@(posedge clk) disable iff (rst)
        (w_req && wdata[2]) |=> req_o[$past(wdata[1:0])]); // R7
endmodule

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;
    localparam int AW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr0 = '0, addr1 = '0;
    logic [7:0] wdata = '0;
    logic [3:0] adv = '0, tc = '0;

    logic [7:0]  rdata0, rdata1;
    logic [63:0] ca0, cc0;
    logic [67:0] ca1, cc1;
    logic [31:0] mode0, mode1;
    logic [3:0]  mask0, mask1, req0, req1;
    logic        off0, off1;

    dma_regfile #(.ADDR_W(AW), .WSHIFT(0)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr0), .wdata(wdata),
        .rdata(rdata0), .adv_chan(adv), .tc_in(tc), .cur_addr_o(ca0), .cur_cnt_o(cc0),
        .mode_o(mode0), .mask_o(mask0), .req_o(req0), .ctrl_off_o(off0));

    dma_regfile #(.ADDR_W(AW), .WSHIFT(1)) u_dut_w (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr1), .wdata(wdata),
        .rdata(rdata1), .adv_chan(adv), .tc_in(tc), .cur_addr_o(ca1), .cur_cnt_o(cc1),
        .mode_o(mode1), .mask_o(mask1), .req_o(req1), .ctrl_off_o(off1));

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_pend = 1'b0;
    logic [7:0] mon_e;
    string      mon_t;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // both instances share every operation; the address is shifted per instance
    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr0 = {4'h0, idx}; addr1 = {3'h0, idx, 1'b0}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected byte, the monitor compares it one clock later
    task automatic rd(input logic [3:0] idx, input logic [7:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; addr0 = {4'h0, idx}; addr1 = {3'h0, idx, 1'b0};
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] a, input logic [3:0] t, input int n);
        @(negedge clk);
        adv = a; tc = t;
        repeat (n) @(negedge clk);
        adv = '0; tc = '0;
    endtask

    task automatic chk_ch1(input string req, input logic [15:0] ea, input logic [15:0] ec);
        check({req, " cur addr"},     32'(ca0[16 +: 16]), 32'(ea));
        check({req, " cur cnt"},      32'(cc0[16 +: 16]), 32'(ec));
        check({req, " cur addr w16"}, 32'(ca1[17 +: 17]), 32'({ea, 1'b0}));
        check({req, " cur cnt w16"},  32'(cc1[17 +: 17]), 32'({ec, 1'b0}));
    endtask

    task automatic chk_pair(input string req, input logic [3:0] a, input logic [3:0] b, input logic [3:0] e);
        check(req, 32'(a), 32'(e));
        check({req, " w16"}, 32'(b), 32'(e));
    endtask

    always @(posedge clk) rd_pend <= rd_en;

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check("scoreboard empty", 32'd1, 32'd0);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check(mon_t, 32'(rdata0), 32'(mon_e));
                check({mon_t, " w16"}, 32'(rdata1), 32'(mon_e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_pair("R1 mask", mask0, mask1, 4'hF);
        chk_pair("R1 req", req0, req1, 4'h0);
        check("R1 off", 32'(off0), 0);
        check("R1 off w16", 32'(off1), 0);
        rd(4'h8, 8'h00, "R1 status");
        rd(4'hF, 8'h0F, "R13 mask read after reset");

        // R2 byte pointer: channel 1 address then count
        wr(4'h2, 8'h34); wr(4'h2, 8'h12);
        wr(4'h3, 8'h10); wr(4'h3, 8'h00);
        chk_ch1("R3 after high write", 16'h1234, 16'h0000);
        rd(4'h2, 8'h34, "R2 R4 addr low");
        rd(4'h2, 8'h12, "R2 R4 addr high");
        rd(4'h3, 8'h10, "R5 cnt low");
        rd(4'h3, 8'h00, "R5 cnt high");

        // R14 progress advance, increment direction
        pulse(4'b0010, 4'h0, 3);
        chk_ch1("R14 advance", 16'h1234, 16'h0003);
        rd(4'h2, 8'h37, "R4 up addr low");
        rd(4'h2, 8'h12, "R4 up addr high");
        rd(4'h3, 8'h0D, "R5 remaining low");
        rd(4'h3, 8'h00, "R5 remaining high");

        // R9 mode write: ch1, decrement, mode 01, op 10, auto-init
        wr(4'hB, 8'h79);
        check("R9 mode ch1", 32'(mode0[15:8]), 32'h79);
        check("R9 mode ch1 w16", 32'(mode1[15:8]), 32'h79);
        check("R9 mode ch0 untouched", 32'(mode0[7:0]), 32'h00);
        rd(4'h2, 8'h31, "R4 down addr low");
        rd(4'h2, 8'h12, "R4 down addr high");

        // R10 pointer clear
        rd(4'h2, 8'h31, "R10 pre-clear low");
        wr(4'hC, 8'h00);
        rd(4'h2, 8'h31, "R10 low after clear");
        wr(4'hC, 8'h00);

        // R3 low byte keeps current, high byte reloads
        wr(4'h2, 8'h00);
        chk_ch1("R3 low write no reload", 16'h1234, 16'h0003);
        wr(4'h2, 8'h20);
        chk_ch1("R3 reload", 16'h2000, 16'h0000);
        rd(4'h3, 8'h10, "R3 R5 cnt low after reload");
        rd(4'h3, 8'h00, "R5 cnt high after reload");
        rd(4'h2, 8'h00, "R3 addr low after reload");
        rd(4'h2, 8'h20, "R3 addr high after reload");

        // R6 command
        wr(4'h8, 8'h04);
        check("R6 accept off", 32'(off0), 1); check("R6 accept off w16", 32'(off1), 1);
        wr(4'h8, 8'h01);
        check("R6 reject keeps 1", 32'(off0), 1); check("R6 reject keeps 1 w16", 32'(off1), 1);
        wr(4'h8, 8'h00);
        check("R6 zero accepted", 32'(off0), 0);
        wr(4'h8, 8'h84);
        check("R6 reject keeps 0", 32'(off0), 0); check("R6 reject keeps 0 w16", 32'(off1), 0);

        // R7 request, R14 terminal count
        wr(4'h9, 8'h06);
        chk_pair("R7 req set ch2", req0, req1, 4'b0100);
        rd(4'h8, 8'h40, "R7 R13 status req");
        pulse(4'h0, 4'b0101, 1);
        rd(4'h8, 8'h45, "R14 tc bits");
        wr(4'h9, 8'h02);
        chk_pair("R7 req clear ch2", req0, req1, 4'b0000);
        rd(4'h8, 8'h01, "R7 clear keeps other tc");

        // R8 / R12 masks
        wr(4'hE, 8'h00);
        chk_pair("R12 clear all", mask0, mask1, 4'h0);
        wr(4'hA, 8'h05);
        chk_pair("R8 set ch1", mask0, mask1, 4'b0010);
        wr(4'hA, 8'h07);
        chk_pair("R8 set ch3", mask0, mask1, 4'b1010);
        wr(4'hA, 8'h01);
        chk_pair("R8 clear ch1", mask0, mask1, 4'b1000);
        wr(4'hF, 8'hF6);
        chk_pair("R12 load all", mask0, mask1, 4'b0110);
        rd(4'hF, 8'h06, "R13 mask read");

        // R13 unused indices
        rd(4'h9, 8'h00, "R13 idx9 zero");
        rd(4'hC, 8'h00, "R13 idx12 zero");

        // R11 master reset
        wr(4'h9, 8'h07);
        wr(4'h8, 8'h04);
        wr(4'h0, 8'hAA);
        wr(4'hD, 8'h00);
        chk_pair("R11 mask", mask0, mask1, 4'hF);
        chk_pair("R11 req", req0, req1, 4'h0);
        check("R11 off", 32'(off0), 0);
        rd(4'h8, 8'h00, "R11 status cleared");
        wr(4'h0, 8'h55); wr(4'h0, 8'h66);
        rd(4'h0, 8'h55, "R11 pointer cleared low");
        rd(4'h0, 8'h66, "R11 pointer cleared high");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check("scoreboard drain", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule